// File: doc/BRIEF.md
# 16-bit Single-Cycle Processor Core

This block executes a small 16-bit load/store instruction set, one instruction per clock. On every cycle it fetches an instruction word from an internal instruction store at the current program counter. It splits the word into a 4-bit operation code and three 4-bit fields, reads two registers, and then does one of five things: an arithmetic or logic operation, a load, a store, a conditional branch or an absolute jump. The program counter update and all state writes happen at the same clock edge.

The register file has sixteen 16-bit entries. Entry 0 always reads zero and entry 1 always reads one, and writes to either are dropped. The 8-bit program counter counts bytes and moves in steps of two. The instruction and data stores are arrays that are read combinationally and written on the clock edge. While reset is held, a single preload port fills them. A debug register read port, the program counter and a store strobe are brought out for observation.

Top module: `cpu16_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the program counter is 0 and registers 2 to 15 read 0.
- R2: The instruction word is {op[15:12], A[11:8], B[7:4], C[3:0]}. Every instruction other than a taken branch (op 7) or a jump (op 8) leaves the program counter at its old value plus 2, modulo 256.
- R3: op 2 writes A+B to register C, and op 3 writes A-B to register C. Both wrap modulo 2^16. A source register may also be the destination, and then the old value is the one read.
- R4: op 4 writes the bitwise AND of A and B to C, and op 5 writes their bitwise OR.
- R5: op 6 writes 1 to C when A is less than B as signed 16-bit numbers, and 0 otherwise.
- R6: Register 0 always reads 0 and register 1 always reads 1. Instructions that name them as a destination leave them unchanged.
- R7: op 0 loads register B from data word (A + sign-extended C) mod 256.
- R8: op 1 stores register B at data word (A + sign-extended C) mod 256. It writes no register, and the store strobe is high only during that instruction's cycle.
- R9: op 7 compares A and B. When they are equal the next PC is PC+2+2*C, with C taken as a signed 4-bit value and the sum wrapping modulo 256. Otherwise the next PC is PC+2. It writes no register.
- R10: op 8 sets the PC to (2 * bits[11:0]) mod 256. It writes no register.
- R11: op values 9 to 15 write no register, store nothing and only advance the PC by 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Preload write enable, effective only while reset is held |
| load_dmem | input | 1 | Preload target: 1 selects the data store, 0 the instruction store |
| load_addr | input | 8 | Preload word address |
| load_data | input | 16 | Preload word |
| dbg_pc | output | 8 | Current program counter |
| dbg_reg_sel | input | 4 | Debug register read index |
| dbg_reg_data | output | 16 | Contents of the selected register |
| dbg_store | output | 1 | High during a cycle in which a store writes the data store |

## Verification
A single clock edge can commit an ALU result into a register that the same instruction also reads as a source. This is provoked with an add whose destination is its own first operand, which doubles a register in one step. The check is that the final register value reflects the old operand and not a value fed back within the cycle. Taken and untaken branches, a backward branch, a wrapping jump and a store followed by a load of the same word are judged from the program counter trace and the register contents that the debug port reads back.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;

   localparam int INSTR_W = 16;
   localparam int FIELD_W = 4;

   typedef enum logic [3:0] {
      OP_LOAD  = 4'd0,
      OP_STORE = 4'd1,
      OP_ADD   = 4'd2,
      OP_SUB   = 4'd3,
      OP_AND   = 4'd4,
      OP_OR    = 4'd5,
      OP_SLT   = 4'd6,
      OP_BEQ   = 4'd7,
      OP_JUMP  = 4'd8
   } opcode_e;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_OR,
      ALU_SLT
   } alu_op_e;

   typedef struct packed {
      logic               rf_we;
      logic [FIELD_W-1:0] rf_waddr;
      logic               load_sel;
      logic               store;
      alu_op_e            alu_op;
      logic               branch;
      logic               jump;
   } ctrl_t;

endpackage

// File: rtl/cpu16_ram.sv
module cpu16_ram #(
   parameter int AW = 8,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 2**AW;

   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("cpu16_ram: AW out of range");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
   parameter int DW     = 16,
   parameter int AW     = 4,
   parameter int NCONST = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] ra_addr,
   output logic [DW-1:0] ra_data,
   input  logic [AW-1:0] rb_addr,
   output logic [DW-1:0] rb_data,
   input  logic [AW-1:0] rc_addr,
   output logic [DW-1:0] rc_data
);

   localparam int NREG = 2**AW;

   generate
      if (NCONST < 0 || NCONST > 2 || NCONST >= NREG) begin : g_bad_const
         $error("cpu16_regfile: NCONST must be 0..2 and below the register count");
      end
   endgenerate

   logic [DW-1:0] regs [NREG];

   // Low entries are hard constants equal to their own index; the rest hold state.
   generate
      for (genvar i = 0; i < NREG; i++) begin : g_reg
         if (i < NCONST) begin : g_const
            assign regs[i] = DW'(i);
         end else begin : g_store
            logic [DW-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                         q <= '0;
               else if (we && waddr == AW'(i))     q <= wdata;
            end
            assign regs[i] = q;
         end
      end
   endgenerate

   assign ra_data = regs[ra_addr];
   assign rb_data = regs[rb_addr];
   assign rc_data = regs[rc_addr];

   // R3: a write to a storage entry is visible on the following cycle.
   assert_writeback_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && waddr >= AW'(NCONST)) |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/cpu16_decode.sv
module cpu16_decode
   import cpu16_pkg::*;
(
   input  logic [FIELD_W-1:0] op,
   input  logic [FIELD_W-1:0] rt,
   input  logic [FIELD_W-1:0] rd,
   output ctrl_t              ctrl
);

   always_comb begin
      ctrl        = '0;
      ctrl.alu_op = ALU_ADD;
      case (op)
         OP_LOAD: begin
            ctrl.rf_we    = 1'b1;
            ctrl.rf_waddr = rt;
            ctrl.load_sel = 1'b1;
         end
         OP_STORE: ctrl.store = 1'b1;
         OP_ADD: begin
            ctrl.rf_we    = 1'b1;
            ctrl.rf_waddr = rd;
            ctrl.alu_op   = ALU_ADD;
         end
         OP_SUB: begin
            ctrl.rf_we    = 1'b1;
            ctrl.rf_waddr = rd;
            ctrl.alu_op   = ALU_SUB;
         end
         OP_AND: begin
            ctrl.rf_we    = 1'b1;
            ctrl.rf_waddr = rd;
            ctrl.alu_op   = ALU_AND;
         end
         OP_OR: begin
            ctrl.rf_we    = 1'b1;
            ctrl.rf_waddr = rd;
            ctrl.alu_op   = ALU_OR;
         end
         OP_SLT: begin
            ctrl.rf_we    = 1'b1;
            ctrl.rf_waddr = rd;
            ctrl.alu_op   = ALU_SLT;
         end
         OP_BEQ:  ctrl.branch = 1'b1;
         OP_JUMP: ctrl.jump   = 1'b1;
         default: ctrl = ctrl;   // op 9..15: no side effect
      endcase
   end

endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
   import cpu16_pkg::*;
#(
   parameter int DW = 16
) (
   input  alu_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y,
   output logic          eq
);

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = DW'($signed(a) < $signed(b));
         default: y = '0;
      endcase
   end

   assign eq = (a == b);

endmodule

// File: rtl/cpu16_pcgen.sv
module cpu16_pcgen #(
   parameter int PC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take_branch,
   input  logic            jump,
   input  logic [3:0]      boff,
   input  logic [PC_W-2:0] jimm,
   output logic [PC_W-1:0] pc
);

   localparam logic [PC_W-1:0] STEP = PC_W'(2);

   logic [PC_W-1:0] pc_plus, br_tgt, jmp_tgt, pc_next;

   assign pc_plus = pc + STEP;
   assign br_tgt  = pc_plus + {{(PC_W-5){boff[3]}}, boff, 1'b0};
   assign jmp_tgt = {jimm, 1'b0};

   always_comb begin
      if (jump)             pc_next = jmp_tgt;
      else if (take_branch) pc_next = br_tgt;
      else                  pc_next = pc_plus;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_next;
   end

   function automatic logic [PC_W-1:0] word_delta(input logic [3:0] w);
      return PC_W'(2 + 2 * int'($signed(w)));
   endfunction

   assert_pc_reset_R1: assert property (@(posedge clk)
      !rst_n |=> pc == '0);

   assert_pc_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pc[0] == 1'b0);

   assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!take_branch && !jump) |=> (pc - $past(pc)) == PC_W'(2));

   assert_branch_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (take_branch && !jump) |=> (pc - $past(pc)) == word_delta($past(boff)));

   assert_jump_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
      jump |=> (pc[0] == 1'b0) && (pc[PC_W-1:1] == $past(jimm)));

endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
   import cpu16_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int PC_W    = 8,
   parameter int DMEM_AW = 8,
   parameter int REG_AW  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic               load_dmem,
   input  logic [DMEM_AW-1:0] load_addr,
   input  logic [DATA_W-1:0]  load_data,
   output logic [PC_W-1:0]    dbg_pc,
   input  logic [REG_AW-1:0]  dbg_reg_sel,
   output logic [DATA_W-1:0]  dbg_reg_data,
   output logic               dbg_store
);

   localparam int IMEM_AW = PC_W - 1;

   generate
      if (REG_AW != FIELD_W) begin : g_bad_reg
         $error("cpu16_core: REG_AW must match the 4-bit register fields");
      end
      if (PC_W < 6 || PC_W > 13) begin : g_bad_pc
         $error("cpu16_core: PC_W must be 6..13");
      end
      if (DATA_W < INSTR_W) begin : g_bad_dw
         $error("cpu16_core: DATA_W must be at least the instruction width");
      end
      if (DMEM_AW < 5 || DMEM_AW > DATA_W || IMEM_AW > DMEM_AW) begin : g_bad_dm
         $error("cpu16_core: DMEM_AW out of range");
      end
   endgenerate

   logic [PC_W-1:0]    pc;
   logic [INSTR_W-1:0] instr;
   logic [3:0]         f_op, f_a, f_b, f_c;
   ctrl_t              ctrl;
   logic [DATA_W-1:0]  a_val, b_val, alu_y, dmem_rdata, wb_data;
   logic               a_eq_b;
   logic [DMEM_AW-1:0] eff_addr;
   logic               imem_we, dmem_we;
   logic [DMEM_AW-1:0] dmem_waddr;
   logic [DATA_W-1:0]  dmem_wdata;

   // Fetch
   assign imem_we = !rst_n && load_en && !load_dmem;

   cpu16_ram #(.AW(IMEM_AW), .DW(INSTR_W)) i_imem (
      .clk   (clk),
      .we    (imem_we),
      .waddr (load_addr[IMEM_AW-1:0]),
      .wdata (load_data[INSTR_W-1:0]),
      .raddr (pc[PC_W-1:1]),
      .rdata (instr)
   );

   assign f_op = instr[15:12];
   assign f_a  = instr[11:8];
   assign f_b  = instr[7:4];
   assign f_c  = instr[3:0];

   // Decode
   cpu16_decode i_decode (
      .op   (f_op),
      .rt   (f_b),
      .rd   (f_c),
      .ctrl (ctrl)
   );

   // Registers
   cpu16_regfile #(.DW(DATA_W), .AW(REG_AW), .NCONST(2)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctrl.rf_we),
      .waddr   (ctrl.rf_waddr),
      .wdata   (wb_data),
      .ra_addr (f_a),
      .ra_data (a_val),
      .rb_addr (f_b),
      .rb_data (b_val),
      .rc_addr (dbg_reg_sel),
      .rc_data (dbg_reg_data)
   );

   // Execute
   cpu16_alu #(.DW(DATA_W)) i_alu (
      .op (ctrl.alu_op),
      .a  (a_val),
      .b  (b_val),
      .y  (alu_y),
      .eq (a_eq_b)
   );

   // Memory access: address adder kept at the data-store index width
   assign eff_addr   = a_val[DMEM_AW-1:0] + {{(DMEM_AW-4){f_c[3]}}, f_c};
   assign dmem_we    = rst_n ? ctrl.store : (load_en && load_dmem);
   assign dmem_waddr = rst_n ? eff_addr   : load_addr;
   assign dmem_wdata = rst_n ? b_val      : load_data;

   cpu16_ram #(.AW(DMEM_AW), .DW(DATA_W)) i_dmem (
      .clk   (clk),
      .we    (dmem_we),
      .waddr (dmem_waddr),
      .wdata (dmem_wdata),
      .raddr (eff_addr),
      .rdata (dmem_rdata)
   );

   assign wb_data = ctrl.load_sel ? dmem_rdata : alu_y;

   // Next program counter
   cpu16_pcgen #(.PC_W(PC_W)) i_pcgen (
      .clk         (clk),
      .rst_n       (rst_n),
      .take_branch (ctrl.branch && a_eq_b),
      .jump        (ctrl.jump),
      .boff        (f_c),
      .jimm        (instr[IMEM_AW-1:0]),
      .pc          (pc)
   );

   assign dbg_pc    = pc;
   assign dbg_store = rst_n && ctrl.store;

   // R8: a store never redirects the program counter.
   assert_store_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_store |=> (dbg_pc - $past(dbg_pc)) == PC_W'(2));

   // R8: a store instruction commits no register.
   assert_store_no_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_store |-> !ctrl.rf_we);

endmodule

// File: tb/test_cpu16_core.sv
`timescale 1ns/1ps
module test_cpu16_core;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_en = 1'b0;
   logic        load_dmem = 1'b0;
   logic [7:0]  load_addr = '0;
   logic [15:0] load_data = '0;
   logic [7:0]  dbg_pc;
   logic [3:0]  dbg_reg_sel = '0;
   logic [15:0] dbg_reg_data;
   logic        dbg_store;

   always #4 clk = ~clk;   // 125 MHz

   cpu16_core i_cpu16_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_en      (load_en),
      .load_dmem    (load_dmem),
      .load_addr    (load_addr),
      .load_data    (load_data),
      .dbg_pc       (dbg_pc),
      .dbg_reg_sel  (dbg_reg_sel),
      .dbg_reg_data (dbg_reg_data),
      .dbg_store    (dbg_store)
   );

   typedef struct {
      logic [7:0] pc;
      logic       st;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   int   checks = 0;
   int   fails  = 0;
   bit   trace_done = 1'b0;

   task automatic check16(string tag, string what, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic push(logic [7:0] pc, logic st, string tag);
      exp_t e;
      e.pc  = pc;
      e.st  = st;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   function automatic logic [15:0] prog(int w);
      case (w)
         0:  return 16'h2112;  // ADD r1,r1 -> r2 = 2
         1:  return 16'h2222;  // ADD r2,r2 -> r2 = 4 (source is destination)
         2:  return 16'h2223;  // ADD r2,r2 -> r3 = 8
         3:  return 16'h3014;  // SUB r0,r1 -> r4 = FFFF
         4:  return 16'h6415;  // SLT r4,r1 -> r5 = 1
         5:  return 16'h6326;  // SLT r3,r2 -> r6 = 0
         6:  return 16'h4437;  // AND r4,r3 -> r7 = 8
         7:  return 16'h5238;  // OR  r2,r3 -> r8 = C
         8:  return 16'h2449;  // ADD r4,r4 -> r9 = FFFE
         9:  return 16'h00A5;  // LW r10 <- [r0+5]
         10: return 16'h00BF;  // LW r11 <- [r0-1] wraps to 255
         11: return 16'h13AE;  // SW r10 -> [r3-2] = 6
         12: return 16'h2220;  // ADD into r0 (dropped)
         13: return 16'h2231;  // ADD into r1 (dropped)
         14: return 16'h01C5;  // LW r12 <- [r1+5] = 6
         15: return 16'h922F;  // op 9: no effect
         16: return 16'hF22F;  // op 15: no effect
         17: return 16'h7233;  // BEQ r2,r3 not taken
         18: return 16'h7442;  // BEQ r4,r4 taken, +2 words -> 42
         19: return 16'h211D;  // skipped
         20: return 16'h211D;  // skipped
         21: return 16'h801E;  // JMP -> 60
         23: return 16'h212E;  // pc 46: ADD r1,r2 -> r14 = 5
         24: return 16'h80A0;  // JMP 0x140 wraps to 64
         30: return 16'h7008;  // pc 60: BEQ r0,r0, -8 words -> 46
         32: return 16'h8020;  // pc 64: JMP to self
         default: return 16'h0000;
      endcase
   endfunction

   task automatic regchk(int idx, logic [15:0] exp, string tag);
      @(negedge clk);
      dbg_reg_sel = 4'(idx);
      #1;
      check16(tag, $sformatf("r%0d", idx), dbg_reg_data, exp);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   // Monitor: pops one expected item per cycle once reset is released.
   initial begin
      wait (rst_n === 1'b1);
      while (exp_q.size() > 0) begin
         exp_t e;
         #1;
         e = exp_q.pop_front();
         check16(e.tag, "pc", {8'h00, dbg_pc}, {8'h00, e.pc});
         check16(e.tag, "store strobe", {15'h0, dbg_store}, {15'h0, e.st});
         @(negedge clk);
      end
      trace_done = 1'b1;
   end

   // Watchdog
   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
   end

   // Driver
   initial begin
      repeat (2) @(negedge clk);
      check16("R1", "pc in reset", {8'h00, dbg_pc}, 16'h0000);
      dbg_reg_sel = 4'd5;
      #1;
      check16("R1", "r5 in reset", dbg_reg_data, 16'h0000);

      for (int w = 0; w < 128; w++) begin
         @(negedge clk);
         load_en = 1'b1; load_dmem = 1'b0; load_addr = 8'(w); load_data = prog(w);
      end
      @(negedge clk); load_en = 1'b1; load_dmem = 1'b1; load_addr = 8'd5;   load_data = 16'h1234;
      @(negedge clk); load_en = 1'b1; load_dmem = 1'b1; load_addr = 8'd255; load_data = 16'h8000;
      @(negedge clk); load_en = 1'b1; load_dmem = 1'b1; load_addr = 8'd0;   load_data = 16'h0000;
      @(negedge clk); load_en = 1'b0;

      push(8'd0, 1'b0, "R1");
      for (int p = 2; p <= 20; p += 2) push(8'(p), 1'b0, "R2");
      push(8'd22, 1'b1, "R8");
      for (int p = 24; p <= 30; p += 2) push(8'(p), 1'b0, "R2");
      push(8'd32, 1'b0, "R11");
      push(8'd34, 1'b0, "R11");
      push(8'd36, 1'b0, "R9");   // untaken branch
      push(8'd42, 1'b0, "R9");   // forward taken branch
      push(8'd60, 1'b0, "R10");
      push(8'd46, 1'b0, "R9");   // backward taken branch
      push(8'd48, 1'b0, "R2");
      push(8'd64, 1'b0, "R10");  // wrapping jump
      push(8'd64, 1'b0, "R10");
      push(8'd64, 1'b0, "R10");

      @(negedge clk);
      rst_n = 1'b1;

      wait (trace_done);
      regchk(0,  16'h0000, "R6");
      regchk(1,  16'h0001, "R6");
      regchk(2,  16'h0004, "R3");
      regchk(3,  16'h0008, "R3");
      regchk(4,  16'hFFFF, "R3");
      regchk(5,  16'h0001, "R5");
      regchk(6,  16'h0000, "R5");
      regchk(7,  16'h0008, "R4");
      regchk(8,  16'h000C, "R4");
      regchk(9,  16'hFFFE, "R3");
      regchk(10, 16'h1234, "R7");
      regchk(11, 16'h8000, "R7");
      regchk(12, 16'h1234, "R8");
      regchk(13, 16'h0000, "R9");
      regchk(14, 16'h0005, "R9");
      regchk(15, 16'h0000, "R11");

      summary();
      $finish;
   end

endmodule